// File: doc/BRIEF.md
# Capture Word Queue with Fill-Level Request

This block is a first-in, first-out store that sits between an image capture path and a bus reader. The capture side pushes 32-bit words; the reader pops them and sees each popped word on a registered data output one cycle later. The block reports how full it is, remembers the highest fill it has reached, and raises a request toward a DMA engine once the fill meets a programmable mark.

Five FIFO events are recorded in a sticky status vector: underflow, overflow, threshold met, full and non-empty. Software clears these bits by writing ones. Each bit has an enable, and the interrupt line is raised by any bit that is both set and enabled. A synchronous flush empties the store and restarts the high-water record.

Top module: `cap_fifo_top`

## Requirements
- R1: After reset the level, the peak, rd_data, evt_status, full, not_empty, thr_hit, dma_req and irq are all zero.
- R2: Accepted words leave in the order they were written; a word popped by rd_en at one rising edge is on rd_data from that edge until the next read.
- R3: level counts the stored words from 0 to 128; full is 1 exactly at 128 and not_empty exactly above 0; a read and a write accepted in the same cycle leave the level unchanged.
- R4: A write while full is discarded, even when a read is accepted in the same cycle, and sets event bit 1 (overflow).
- R5: A read while empty sets rd_data to zero, leaves the level at 0 and sets event bit 0 (underflow); a write in the same cycle is still accepted.
- R6: peak holds the largest level reached since reset or the last flush.
- R7: thr_field encodes a mark of thr_field + 1 words (0 means 1, 127 means 128); thr_hit is 1 while level is at or above the mark.
- R8: dma_req equals thr_hit while dma_en is 1 and stays 0 while dma_en is 0.
- R9: Event bits are sticky; on each rising edge bit 2 (threshold met), bit 3 (full) and bit 4 (non-empty) are set when that condition held on the outputs just before the edge.
- R10: When clr_we is 1, every status bit whose clr_mask bit is 1 is cleared at the next edge; bits with a 0 in clr_mask are unchanged.
- R11: An event that sets a bit in the same cycle as its clear leaves the bit set.
- R12: irq is 1 exactly when some status bit and its evt_en bit are both 1; a bit whose enable is 0 still records its event.
- R13: flush sets level and peak to zero, discards the stored words and ignores wr_en and rd_en in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous empty and peak restart |
| wr_en | input | 1 | Push request |
| wr_data | input | 32 | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 32 | Last popped word (zero after an empty read) |
| level | output | 8 | Stored word count |
| peak | output | 8 | High-water level |
| full | output | 1 | Level equals depth |
| not_empty | output | 1 | Level above zero |
| thr_field | input | 7 | Mark minus one |
| thr_hit | output | 1 | Level at or above the mark |
| dma_en | input | 1 | Request gate |
| dma_req | output | 1 | Request toward the DMA engine |
| evt_en | input | 5 | Per-event interrupt enables |
| clr_we | input | 1 | Clear strobe for the status vector |
| clr_mask | input | 5 | Ones select bits to clear |
| evt_status | output | 5 | Sticky event bits |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume rst_n is held low until the clock runs and that thr_field, dma_en and evt_en change only between edges; they make no assumption about wr_en, rd_en, flush or clr_we, which may all be active together. The stimulus drives every input just after a falling edge so each value is stable across the next rising edge, and it deliberately combines reads with writes at empty and full, clears with same-cycle sets, and flush with pending pushes and pops.

// File: rtl/cap_fifo_pkg.sv
package cap_fifo_pkg;
  localparam int EVT_N = 5;

  typedef enum int {
    EV_UNDER = 0,
    EV_OVER  = 1,
    EV_MARK  = 2,
    EV_FULL  = 3,
    EV_AVAIL = 4
  } evt_idx_e;

  // level after one cycle of accepted push/pop
  function automatic int unsigned lvl_step(int unsigned lvl, bit push, bit pop);
    return lvl + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  function automatic int unsigned hi_water(int unsigned pk, int unsigned lvl);
    return (lvl > pk) ? lvl : pk;
  endfunction

  // threshold field is stored as words minus one
  function automatic int unsigned mark_words(int unsigned field);
    return field + 1;
  endfunction

  function automatic int unsigned ptr_wrap(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/cap_fifo_store.sv
module cap_fifo_store
  import cap_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  peak,
  output logic              wr_drop,
  output logic              rd_starve
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  lvl_nxt;
  logic              is_full, is_empty, wr_ok, rd_ok;

  assign is_full   = (level == LVL_W'(DEPTH));
  assign is_empty  = (level == '0);
  assign wr_ok     = wr_en & ~is_full & ~flush;
  assign rd_ok     = rd_en & ~is_empty & ~flush;
  assign wr_drop   = wr_en & is_full & ~flush;
  assign rd_starve = rd_en & is_empty & ~flush;
  assign lvl_nxt   = LVL_W'(lvl_step(int'(level), wr_ok, rd_ok));

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      peak    <= '0;
      rd_data <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      peak   <= '0;
    end else begin
      if (wr_ok) wr_ptr <= PTR_W'(ptr_wrap(int'(wr_ptr), DEPTH));
      if (rd_ok) begin
        rd_ptr  <= PTR_W'(ptr_wrap(int'(rd_ptr), DEPTH));
        rd_data <= mem[rd_ptr];
      end else if (rd_starve) begin
        rd_data <= '0;
      end
      level <= lvl_nxt;
      peak  <= LVL_W'(hi_water(int'(peak), int'(lvl_nxt)));
    end
  end

  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  a_r4_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && !rd_en) |=> level == $past(level));
  a_r5_starve_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_starve |=> (rd_data == '0));
  a_r6_peak_floor: assert property (@(posedge clk) disable iff (!rst_n)
    peak >= level);
  a_r13_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && peak == '0));
endmodule

// File: rtl/cap_fifo_events.sv
module cap_fifo_events #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] enable,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_eff) | set_vec;
  end

  assign irq = |(status & enable);

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));
  a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status & $past(clr_mask & ~set_vec)) == '0));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/cap_fifo_top.sv
module cap_fifo_top
  import cap_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  localparam int THR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  peak,
  output logic              full,
  output logic              not_empty,
  input  logic [THR_W-1:0]  thr_field,
  output logic              thr_hit,
  input  logic              dma_en,
  output logic              dma_req,
  input  logic [EVT_N-1:0]  evt_en,
  input  logic              clr_we,
  input  logic [EVT_N-1:0]  clr_mask,
  output logic [EVT_N-1:0]  evt_status,
  output logic              irq
);
  logic             wr_drop, rd_starve;
  logic [LVL_W-1:0] mark;
  logic [EVT_N-1:0] set_vec;

  cap_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .level(level), .peak(peak), .wr_drop(wr_drop), .rd_starve(rd_starve)
  );

  assign mark      = LVL_W'(mark_words(int'(thr_field)));
  assign full      = (level == LVL_W'(DEPTH));
  assign not_empty = (level != '0);
  assign thr_hit   = (level >= mark);
  assign dma_req   = dma_en & thr_hit;

  always_comb begin
    set_vec           = '0;
    set_vec[EV_UNDER] = rd_starve;
    set_vec[EV_OVER]  = wr_drop;
    set_vec[EV_MARK]  = thr_hit;
    set_vec[EV_FULL]  = full;
    set_vec[EV_AVAIL] = not_empty;
  end

  cap_fifo_events #(.N(EVT_N)) u_events (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_we(clr_we),
    .clr_mask(clr_mask), .enable(evt_en), .status(evt_status), .irq(irq)
  );

  a_r8_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> dma_en);
  a_r4_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> evt_status[EV_OVER]);
  a_r5_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_starve |=> evt_status[EV_UNDER]);
  a_r12_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((evt_status & evt_en) != '0));
endmodule

// File: tb/tb_cap_fifo_top.sv
`timescale 1ns/1ps
module tb_cap_fifo_top;
  logic clk = 0, rst_n = 0, flush = 0, wr_en = 0, rd_en = 0, dma_en = 0, clr_we = 0;
  logic [31:0] wr_data = '0;
  logic [6:0]  thr_field = '0;
  logic [4:0]  evt_en = '0, clr_mask = '0;
  logic [31:0] rd_data;
  logic [7:0]  level, peak;
  logic        full, not_empty, thr_hit, dma_req, irq;
  logic [4:0]  evt_status;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] q[$];
  int m_peak = 0;
  logic [4:0] m_st = '0;
  logic [31:0] m_rd = '0;

  always #2 clk = ~clk;

  cap_fifo_top dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .level(level), .peak(peak), .full(full),
    .not_empty(not_empty), .thr_field(thr_field), .thr_hit(thr_hit),
    .dma_en(dma_en), .dma_req(dma_req), .evt_en(evt_en), .clr_we(clr_we),
    .clr_mask(clr_mask), .evt_status(evt_status), .irq(irq)
  );

  task automatic check(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare every observable against the scoreboard model
  task automatic monitor(string tag);
    int lv = q.size();
    int mk = int'(thr_field) + 1;
    check("R2 rd_data", rd_data, m_rd);
    check("R3 level", level, lv);
    check("R3 full", full, lv == 128);
    check("R3 not_empty", not_empty, lv > 0);
    check("R6 peak", peak, m_peak);
    check("R7 thr_hit", thr_hit, lv >= mk);
    check("R8 dma_req", dma_req, dma_en && lv >= mk);
    check(tag, evt_status, m_st);
    check("R12 irq", irq, (m_st & evt_en) != 0);
  endtask

  // driver: one clock of stimulus, model update, then monitor
  task automatic step(bit w, logic [31:0] d, bit r, bit fl, bit cw, logic [4:0] cm, string tag);
    int lv, mk;
    logic [4:0] setv;
    wr_en = w; wr_data = d; rd_en = r; flush = fl; clr_we = cw; clr_mask = cm;
    lv = q.size();
    mk = int'(thr_field) + 1;
    setv = '0;
    setv[0] = r && lv == 0 && !fl;
    setv[1] = w && lv == 128 && !fl;
    setv[2] = lv >= mk;
    setv[3] = lv == 128;
    setv[4] = lv > 0;
    m_st = (m_st & ~(cw ? cm : 5'd0)) | setv;
    if (fl) begin
      q.delete();
      m_peak = 0;
    end else begin
      if (r) m_rd = (lv > 0) ? q.pop_front() : 32'd0;
      if (w && lv < 128) q.push_back(d);
      if (q.size() > m_peak) m_peak = q.size();
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0; flush = 0; clr_we = 0;
    monitor(tag);
  endtask

  task automatic idle(string tag); step(0, 0, 0, 0, 0, 0, tag); endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    evt_en = 5'b11111;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 level", level, 0);
    check("R1 peak", peak, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 status", evt_status, 0);
    check("R1 irq", irq, 0);
    check("R1 dma_req", dma_req, 0);
    check("R1 full", full, 0);
    check("R1 not_empty", not_empty, 0);
    check("R1 thr_hit", thr_hit, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 ordering, R9 non-empty event
    for (int i = 0; i < 5; i++) step(1, 32'hA000_0000 + i, 0, 0, 0, 0, "R9 status");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0, "R9 status");
    // R10 clear only bits selected; R5 underflow
    step(0, 0, 1, 0, 0, 0, "R5 status");
    idle("R5 status");
    step(0, 0, 0, 0, 1, 5'b00001, "R10 status");
    step(0, 0, 0, 0, 1, 5'b11111, "R10 status");
    // R5 read+write at empty: write accepted
    step(1, 32'h1234_5678, 1, 0, 0, 0, "R5 status");
    step(0, 0, 1, 0, 0, 0, "R2 status");
    step(0, 0, 0, 0, 1, 5'b11111, "R10 status");

    // R12 masking: only full enabled
    evt_en = 5'b01000;
    // R7/R8 threshold with dma off, then on
    thr_field = 7'd3;
    for (int i = 0; i < 5; i++) step(1, 32'hB000_0000 + i, 0, 0, 0, 0, "R12 status");
    dma_en = 1; idle("R8 status");
    thr_field = 7'd4; idle("R7 status");
    thr_field = 7'd5; idle("R7 status");
    // R11 clear of non-empty while still set-conditioned
    step(0, 0, 0, 0, 1, 5'b10000, "R11 status");
    // fill to full, overflow
    thr_field = 7'd127;
    while (q.size() < 128) step(1, 32'hC000_0000 + q.size(), 0, 0, 0, 0, "R3 status");
    idle("R7 status");
    step(1, 32'hDEAD_BEEF, 0, 0, 0, 0, "R4 status");
    // R4 full with read and write together: write dropped
    step(1, 32'hFEED_0001, 1, 0, 0, 0, "R4 status");
    step(1, 32'hFEED_0002, 0, 0, 0, 0, "R3 status");
    // R3 simultaneous rd/wr mid-level keeps level
    step(0, 0, 1, 0, 0, 0, "R3 status");
    for (int i = 0; i < 4; i++) step(1, 32'hE000_0000 + i, 1, 0, 0, 0, "R3 status");
    // drain, R6 peak stays 128
    while (q.size() > 0) step(0, 0, 1, 0, 0, 0, "R6 status");
    evt_en = 5'b00011;
    step(0, 0, 0, 0, 1, 5'b11111, "R12 status");
    // R13 flush with pending push/pop
    for (int i = 0; i < 3; i++) step(1, 32'h5000_0000 + i, 0, 0, 0, 0, "R13 status");
    step(1, 32'h6000_0000, 1, 1, 0, 0, "R13 status");
    step(0, 0, 1, 0, 0, 0, "R13 status");
    step(1, 32'h7000_0001, 0, 0, 0, 0, "R13 status");
    step(0, 0, 1, 0, 1, 5'b11111, "R11 status");
    idle("R9 status");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule